// File: doc/BRIEF.md
# Line-Doubled Framebuffer Pixel Streamer

This block turns a byte-per-pixel framebuffer into a pixel stream for a video output. Each time the timing generator signals the start of a visible line, the block reads one row of pixel bytes through a synchronous memory read port. The read port has one cycle of latency. The block places the bytes on an 8-bit pixel output at a fixed pace of one byte every few clocks. When the row has been sent, it forces a single zero byte so that the output rests at black until the next line.

Every framebuffer row is shown on two consecutive display lines, which halves the vertical resolution. The row pointer moves forward by one row only after a line whose successor has an even line number. It wraps back to zero when moving forward would reach the end of the screen area. A pulse at the top of the visible region reloads the pointer from a screen base address. Outside the visible region the block issues no reads and holds the output at zero.

Top module: `rowpair_scanout`

## Requirements
- R1: After reset, `pix_out` is zero, `rd_en` is low, and the row pointer is zero, so the first visible line reads from address 0.
- R2: On the clock edge that samples `line_go` high while `vis_on` is high, a line starts. Take that edge as edge 0. For k = 0 .. LINE_PIX-1, `rd_en` is high for exactly the one cycle that follows edge k×PIX_DIV, with `rd_addr` = row pointer + k. `rd_en` is low in every other cycle of the line.
- R3: The byte read for pixel k appears on `pix_out` at edge k×PIX_DIV+2 and is held for PIX_DIV cycles.
- R4: At edge LINE_PIX×PIX_DIV+2, after the last pixel, `pix_out` becomes zero and stays zero until the next line's first pixel.
- R5: When a line completes and `line_idx` is odd (the next line number is even), the row pointer moves forward by LINE_PIX. When `line_idx` is even, the pointer is unchanged, so the same row is repeated.
- R6: If moving forward would make the row pointer equal to or greater than SCREEN_BYTES, the pointer becomes zero instead.
- R7: A `frame_top` pulse loads the row pointer from `scr_base`.
- R8: A `line_go` that arrives while `vis_on` is low is ignored: no `rd_en`, `pix_out` stays zero, and the row pointer does not change.
- R9: `vis_on` going low clears `pix_out` to zero at the next edge and stops the reads. A line cut short this way does not move the row pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_go | input | 1 | Line-start strobe, one cycle |
| vis_on | input | 1 | High while the current line lies in the visible region |
| line_idx | input | LN_W | Number of the current line |
| frame_top | input | 1 | Pulse at the start of the visible region |
| scr_base | input | ADDR_W | Screen base address loaded by `frame_top` |
| rd_data | input | PIX_W | Read data, valid one cycle after `rd_en` |
| pix_out | output | PIX_W | Pixel byte output |
| rd_addr | output | ADDR_W | Framebuffer read address |
| rd_en | output | 1 | Framebuffer read strobe |

## Verification
All timing is counted from the edge that samples `line_go`:
- Read strobes fall due in the cycle after edges k×PIX_DIV.
- Pixel k is due at edge k×PIX_DIV+2, because the memory adds one register and the output stage adds another.
- The blanking zero is due at edge LINE_PIX×PIX_DIV+2.
- A falling `vis_on` takes effect at the very next edge.

The bench counts falling edges from the strobe edge and samples every output in the middle of the cycle. Each line is checked against this schedule cycle by cycle, and the expected row pointer is kept arithmetically from the line numbers, the screen size and the base loads.

// File: rtl/rowpair_pkg.sv
package rowpair_pkg;

   // One slot of the output pipeline: a load of a memory byte or of a forced zero
   typedef struct packed {
      logic load;
      logic zero;
   } slot_req_t;

endpackage

// File: rtl/rowpair_pacer.sv
module rowpair_pacer #(
   parameter int LINE_PIX = 160,
   parameter int PIX_DIV  = 5,
   parameter int IDX_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_go,
   input  logic             vis_on,
   output logic             pix_slot,
   output logic             blank_slot,
   output logic [IDX_W-1:0] slot_idx
);

   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(LINE_PIX);

   logic             busy;
   logic             tick;
   logic             start;
   logic [IDX_W-1:0] idx;

   assign start = line_go & vis_on;

   generate
      if (PIX_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(PIX_DIV);
         localparam logic [DW-1:0] DIV_TOP = DW'(PIX_DIV - 1);
         logic [DW-1:0] dcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dcnt <= '0;
            else if (start || !busy || dcnt == DIV_TOP)
               dcnt <= '0;
            else
               dcnt <= dcnt + 1'b1;
         end

         assign tick = (dcnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (!vis_on) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy && tick) begin
         if (idx == LAST_SLOT)
            busy <= 1'b0;
         else
            idx <= idx + 1'b1;
      end
   end

   assign pix_slot   = busy & vis_on & tick & (idx != LAST_SLOT);
   assign blank_slot = busy & vis_on & tick & (idx == LAST_SLOT);
   assign slot_idx   = idx;

endmodule

// File: rtl/rowpair_ptr.sv
module rowpair_ptr #(
   parameter int ADDR_W       = 16,
   parameter int LINE_PIX     = 160,
   parameter int SCREEN_BYTES = 40960,
   parameter int LN_W         = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_top,
   input  logic [ADDR_W-1:0] scr_base,
   input  logic              line_done,
   input  logic [LN_W-1:0]   line_idx,
   output logic [ADDR_W-1:0] row_addr
);

   localparam logic [ADDR_W:0] STEP  = (ADDR_W+1)'(LINE_PIX);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(SCREEN_BYTES);

   logic [ADDR_W:0] stepped;
   logic [LN_W-1:0] next_line;
   logic            next_even;

   assign next_line = line_idx + 1'b1;
   assign next_even = (next_line % LN_W'(2)) == '0;
   assign stepped   = {1'b0, row_addr} + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         row_addr <= '0;
      else if (frame_top)
         row_addr <= scr_base;
      else if (line_done && next_even)
         row_addr <= (stepped >= LIMIT) ? '0 : stepped[ADDR_W-1:0];
   end

endmodule

// File: rtl/rowpair_out.sv
module rowpair_out
   import rowpair_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vis_on,
   input  logic             pix_slot,
   input  logic             blank_slot,
   input  logic [PIX_W-1:0] rd_data,
   output logic [PIX_W-1:0] pix_out
);

   slot_req_t req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req     <= '0;
         pix_out <= '0;
      end else if (!vis_on) begin
         req     <= '0;
         pix_out <= '0;
      end else begin
         req.load <= pix_slot | blank_slot;
         req.zero <= blank_slot;
         if (req.load)
            pix_out <= req.zero ? '0 : rd_data;
      end
   end

endmodule

// File: rtl/rowpair_scanout.sv
module rowpair_scanout #(
   parameter int PIX_W        = 8,
   parameter int ADDR_W       = 16,
   parameter int LINE_PIX     = 160,
   parameter int PIX_DIV      = 5,
   parameter int SCREEN_BYTES = 40960,
   parameter int LN_W         = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_go,
   input  logic              vis_on,
   input  logic [LN_W-1:0]   line_idx,
   input  logic              frame_top,
   input  logic [ADDR_W-1:0] scr_base,
   input  logic [PIX_W-1:0]  rd_data,
   output logic [PIX_W-1:0]  pix_out,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_en
);

   localparam int IDX_W = $clog2(LINE_PIX + 1);

   generate
      if (LINE_PIX < 1) begin : g_bad_len
         $error("rowpair_scanout: LINE_PIX must be at least 1");
      end
      if (PIX_DIV < 1) begin : g_bad_div
         $error("rowpair_scanout: PIX_DIV must be at least 1");
      end
      if (SCREEN_BYTES < LINE_PIX || SCREEN_BYTES % LINE_PIX != 0) begin : g_bad_scr
         $error("rowpair_scanout: SCREEN_BYTES must be a whole number of rows");
      end
      if (SCREEN_BYTES > (1 << ADDR_W) || IDX_W > ADDR_W) begin : g_bad_aw
         $error("rowpair_scanout: ADDR_W too narrow");
      end
   endgenerate

   logic             pix_slot;
   logic             blank_slot;
   logic [IDX_W-1:0] slot_idx;
   logic [ADDR_W-1:0] row_addr;

   rowpair_pacer #(
      .LINE_PIX (LINE_PIX),
      .PIX_DIV  (PIX_DIV),
      .IDX_W    (IDX_W)
   ) u_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_go    (line_go),
      .vis_on     (vis_on),
      .pix_slot   (pix_slot),
      .blank_slot (blank_slot),
      .slot_idx   (slot_idx)
   );

   rowpair_ptr #(
      .ADDR_W       (ADDR_W),
      .LINE_PIX     (LINE_PIX),
      .SCREEN_BYTES (SCREEN_BYTES),
      .LN_W         (LN_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_top (frame_top),
      .scr_base  (scr_base),
      .line_done (blank_slot),
      .line_idx  (line_idx),
      .row_addr  (row_addr)
   );

   rowpair_out #(
      .PIX_W (PIX_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .vis_on     (vis_on),
      .pix_slot   (pix_slot),
      .blank_slot (blank_slot),
      .rd_data    (rd_data),
      .pix_out    (pix_out)
   );

   assign rd_en   = pix_slot;
   assign rd_addr = row_addr + ADDR_W'(slot_idx);

endmodule

// File: rtl/rowpair_scanout_chk.sv
module rowpair_scanout_chk #(
   parameter int PIX_W   = 8,
   parameter int PIX_DIV = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_go,
   input logic             vis_on,
   input logic             rd_en,
   input logic [PIX_W-1:0] pix_out
);

   // R2
   rd_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> vis_on);

   // R9
   hidden_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_on |=> (pix_out == '0));

   // R8
   hidden_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_go && !vis_on) |=> !rd_en);

   generate
      if (PIX_DIV > 1) begin : g_gap
         // R2
         slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !line_go) |=> !rd_en);
      end
   endgenerate

endmodule

bind rowpair_scanout rowpair_scanout_chk #(
   .PIX_W   (PIX_W),
   .PIX_DIV (PIX_DIV)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .line_go (line_go),
   .vis_on  (vis_on),
   .rd_en   (rd_en),
   .pix_out (pix_out)
);

// File: tb/rowpair_scanout_test.sv
module rowpair_scanout_test;

   localparam int PW  = 8;
   localparam int AW  = 8;
   localparam int N   = 4;
   localparam int D   = 3;
   localparam int SCR = 12;
   localparam int LNW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           line_go = 1'b0;
   logic           vis_on = 1'b0;
   logic [LNW-1:0] line_idx = '0;
   logic           frame_top = 1'b0;
   logic [AW-1:0]  scr_base = '0;
   logic [PW-1:0]  rd_data = '0;
   logic [PW-1:0]  pix_out;
   logic [AW-1:0]  rd_addr;
   logic           rd_en;

   int n_chk = 0;
   int n_bad = 0;
   int exp_base = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rowpair_scanout #(
      .PIX_W (PW), .ADDR_W (AW), .LINE_PIX (N), .PIX_DIV (D),
      .SCREEN_BYTES (SCR), .LN_W (LNW)
   ) uut (
      .clk (clk), .rst_n (rst_n), .line_go (line_go), .vis_on (vis_on),
      .line_idx (line_idx), .frame_top (frame_top), .scr_base (scr_base),
      .rd_data (rd_data), .pix_out (pix_out), .rd_addr (rd_addr), .rd_en (rd_en)
   );

   function automatic logic [PW-1:0] pat(input int a);
      return PW'((a * 37 + 11) & 255);
   endfunction

   // framebuffer model with one cycle of read latency
   always @(posedge clk)
      if (rd_en) rd_data <= pat(int'(rd_addr));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_line(input int lnum, input string tag);
      @(negedge clk);
      line_go  = 1'b1;
      vis_on   = 1'b1;
      line_idx = LNW'(lnum);
      @(negedge clk);
      line_go = 1'b0;
      for (int j = 0; j <= N * D + 3; j++) begin
         if (j % D == 0 && j / D < N) begin
            check(rd_en === 1'b1, "R2 strobe", int'(rd_en), 1);
            check(rd_addr === AW'(exp_base + j / D), (j == 0) ? tag : "R2 addr",
                  int'(rd_addr), exp_base + j / D);
         end else begin
            check(rd_en === 1'b0, "R2 idle", int'(rd_en), 0);
         end
         if (j >= 2 && (j - 2) % D == 0) begin
            if ((j - 2) / D < N)
               check(pix_out === pat(exp_base + (j - 2) / D), "R3 pixel",
                     int'(pix_out), int'(pat(exp_base + (j - 2) / D)));
            else
               check(pix_out === '0, "R4 blank", int'(pix_out), 0);
         end
         if (j == N * D + 3)
            check(pix_out === '0, "R4 rest", int'(pix_out), 0);
         @(negedge clk);
      end
      if (lnum % 2 == 1) begin
         exp_base += N;
         if (exp_base >= SCR) exp_base = 0;
      end
   endtask

   task automatic load_base(input int b);
      @(negedge clk);
      frame_top = 1'b1;
      scr_base  = AW'(b);
      @(negedge clk);
      frame_top = 1'b0;
      exp_base  = b;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs at rest
      check(pix_out === '0, "R1 pix", int'(pix_out), 0);
      check(rd_en === 1'b0, "R1 rd_en", int'(rd_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(pix_out === '0, "R1 pix after release", int'(pix_out), 0);

      // R1: first line reads from address 0 without a base load
      run_line(0, "R1 start addr");

      // R5 doubling and R6 wrap across three rows
      for (int l = 1; l < 8; l++)
         run_line(l, (l >= 6) ? "R6 wrapped row" : "R5 row step");

      // R8: hidden line_go does nothing
      @(negedge clk);
      vis_on   = 1'b0;
      line_go  = 1'b1;
      line_idx = LNW'(8);
      @(negedge clk);
      line_go = 1'b0;
      for (int j = 0; j <= N * D + 3; j++) begin
         check(rd_en === 1'b0, "R8 no read", int'(rd_en), 0);
         check(pix_out === '0, "R8 dark", int'(pix_out), 0);
         @(negedge clk);
      end
      run_line(9, "R8 pointer kept");

      // R7: base reload
      load_base(4);
      run_line(0, "R7 base load");

      // R9: visible flag drops mid-line
      @(negedge clk);
      vis_on   = 1'b1;
      line_go  = 1'b1;
      line_idx = LNW'(1);
      @(negedge clk);
      line_go = 1'b0;
      repeat (4) @(negedge clk);
      check(pix_out === pat(exp_base), "R3 before drop", int'(pix_out), int'(pat(exp_base)));
      vis_on = 1'b0;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         check(pix_out === '0, "R9 dark", int'(pix_out), 0);
         check(rd_en === 1'b0, "R9 no read", int'(rd_en), 0);
      end
      run_line(1, "R9 pointer kept");
      run_line(2, "R5 after abort");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule